// File: doc/BRIEF.md
# Oscillator Amplitude Regulation State Machine

This block closes the amplitude loop of a crystal or LC oscillator with digital logic instead of an analog loop amplifier. It asks an external converter for a reading of the measured peak amplitude and compares the reading with a programmable target. A dead band of a programmable width sits around that target. If the reading is below the band, the block raises a bias code that goes to an external current DAC by one LSB. If the reading is above the band, it lowers the code by one LSB. The code saturates at both ends. After each step the block waits a programmable number of cycles so that the oscillator and the detector can settle. Then it takes the next reading.

After reset the block calibrates once, on its own, to remove process spread. Calibration ends when a fixed number of consecutive readings fall inside the dead band, and a sticky done flag is then raised. After calibration the loop runs only while a window input is high. The system grants that window in quiet periods to follow temperature drift. If the window closes while a conversion is in progress, that conversion is completed and its step is applied. The block then parks in a hold state. In hold no request is made and the code is frozen, so the bias adds no correction activity between windows.

Top module: `osc_amp_regulator`

## Requirements
- R1: While reset is high, and on the first cycle after it, `dac_code_o` equals mid-scale (2^(CODE_W-1), 128 by default), `cal_done_o` is 0 and `adc_req_o` is 0.
- R2: Calibration starts without any window. `adc_req_o` rises after the first rising edge following reset release, whatever `win_i` is.
- R3: Each accepted reading A is compared with target T and band B (all unsigned). If A + B < T the code rises by one. If A > T + B the code falls by one. Otherwise the code is unchanged, so both band edges count as inside.
- R4: The code saturates. An upward step at 2^CODE_W-1 leaves it there, and a downward step at 0 leaves it at 0. The code never wraps.
- R5: `adc_req_o` stays high until a cycle in which `adc_done_i` is sampled high. `adc_data_i` is taken in that same cycle.
- R6: When the loop continues, the next `adc_req_o` rises exactly S+3 rising edges after the edge that accepted `adc_done_i`. S is the `settle_i` value held during that conversion.
- R7: `cal_done_o` rises after LOCK_COUNT (default 3) consecutive in-band readings during calibration. It stays high until reset.
- R8: After calibration, if `win_i` is low when a step is applied, the block enters hold. In hold `adc_req_o` stays low and `dac_code_o` stays frozen.
- R9: If `win_i` falls while a request is pending, the conversion still completes and its step is applied. Hold follows.
- R10: In hold, a high `win_i` raises `adc_req_o` after the next rising edge.
- R11: `dac_code_o` changes by at most one LSB per accepted reading, and only on the step that follows a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 1 | Correction window grant after calibration |
| target_i | input | DATA_W | Target amplitude reading |
| band_i | input | DATA_W | Dead-band half width in LSBs |
| settle_i | input | SETTLE_W | Wait cycles after each step |
| adc_req_o | output | 1 | Conversion request, held until done |
| adc_done_i | input | 1 | Conversion complete |
| adc_data_i | input | DATA_W | Measured amplitude reading |
| dac_code_o | output | CODE_W | Bias code to the DAC |
| cal_done_o | output | 1 | Power-up calibration finished (sticky) |

## Verification
The bench drives readings on both exact edges of the dead band and one LSB beyond each edge. An off-by-one comparison would step when it should rest, or rest when it should step. It pushes the code into both rails for several extra readings. Logic that wraps would jump from full scale to zero, or from zero to full scale. It closes the window while a request is pending. A design that aborts early would lose the pending step, and one that ignores the window would keep requesting. It also counts the exact gap between each accepted reading and the next request for random settle values, and checks that the done flag rises only after the required run of in-band readings.

// File: rtl/osc_amp_pkg.sv
package osc_amp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_DECIDE,
        ST_UPDATE,
        ST_SETTLE,
        ST_HOLD
    } ctl_state_e;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_UP,
        STEP_DOWN
    } step_dir_e;

    typedef struct packed {
        step_dir_e dir;
        logic      in_band;
    } verdict_t;

    // Classify a reading against target +/- band; band edges are inside.
    function automatic verdict_t judge(int unsigned amp, int unsigned tgt, int unsigned band);
        verdict_t v;
        v.dir     = STEP_NONE;
        v.in_band = 1'b0;
        if (amp + band < tgt) begin
            v.dir = STEP_UP;
        end else if (amp > tgt + band) begin
            v.dir = STEP_DOWN;
        end else begin
            v.in_band = 1'b1;
        end
        return v;
    endfunction

    // One-LSB step clamped to [0, top].
    function automatic int unsigned sat_step(int unsigned cur, int unsigned top, step_dir_e d);
        int unsigned r;
        r = cur;
        if (d == STEP_UP && cur < top) begin
            r = cur + 1;
        end else if (d == STEP_DOWN && cur != 0) begin
            r = cur - 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/amp_decider.sv
module amp_decider
    import osc_amp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] amp_i,
    input  logic              judge_i,
    input  logic [DATA_W-1:0] target_i,
    input  logic [DATA_W-1:0] band_i,
    output verdict_t          verdict_o
);

    logic [DATA_W-1:0] amp_q;
    verdict_t          verdict_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q <= '0;
        end else if (cap_i) begin
            amp_q <= amp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '{dir: STEP_NONE, in_band: 1'b0};
        end else if (judge_i) begin
            verdict_q <= judge(32'(amp_q), 32'(target_i), 32'(band_i));
        end
    end

    assign verdict_o = verdict_q;

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
    import osc_amp_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  step_dir_e         dir_i,
    output logic [CODE_W-1:0] code_o
);

    localparam int unsigned CODE_MAX = (2 ** CODE_W) - 1;
    localparam int unsigned CODE_MID = 2 ** (CODE_W - 1);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_W'(CODE_MID);
        end else if (step_i) begin
            code_q <= CODE_W'(sat_step(32'(code_q), CODE_MAX, dir_i));
        end
    end

    assign code_o = code_q;

    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_i == STEP_UP && code_q == CODE_W'(CODE_MAX)) |=> (code_q == CODE_W'(CODE_MAX)))
        else $error("code wrapped above full scale"); // R4
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        (step_i && dir_i == STEP_DOWN && code_q == '0) |=> (code_q == '0))
        else $error("code wrapped below zero"); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(code_q))
        else $error("code moved without a step"); // R11

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] value_i,
    input  logic                count_i,
    output logic                expired_o
);

    logic [SETTLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (count_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
    parameter int LOCK_COUNT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step_i,
    input  logic in_band_i,
    output logic done_o,
    output logic done_next_o
);

    localparam int CW = $clog2(LOCK_COUNT + 1);

    logic [CW-1:0] run_q, run_d;
    logic          done_q, done_d;

    always_comb begin
        run_d  = run_q;
        done_d = done_q;
        if (step_i) begin
            if (!in_band_i) begin
                run_d = '0;
            end else if (run_q != CW'(LOCK_COUNT)) begin
                run_d = run_q + 1'b1;
            end
            if (run_d == CW'(LOCK_COUNT)) begin
                done_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            done_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            done_q <= done_d;
        end
    end

    assign done_o      = done_q;
    assign done_next_o = done_d;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q)
        else $error("calibration done flag dropped"); // R7

endmodule

// File: rtl/osc_amp_regulator.sv
module osc_amp_regulator
    import osc_amp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CODE_W     = 8,
    parameter int SETTLE_W   = 8,
    parameter int LOCK_COUNT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                win_i,
    input  logic [DATA_W-1:0]   target_i,
    input  logic [DATA_W-1:0]   band_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                adc_req_o,
    input  logic                adc_done_i,
    input  logic [DATA_W-1:0]   adc_data_i,
    output logic [CODE_W-1:0]   dac_code_o,
    output logic                cal_done_o
);

    ctl_state_e state_q, state_d;
    verdict_t   verdict;
    logic       cap, judge_en, step_en, settle_cnt, settle_done;
    logic       done_q, done_next;

    assign cap        = (state_q == ST_SAMPLE) && adc_done_i;
    assign judge_en   = (state_q == ST_DECIDE);
    assign step_en    = (state_q == ST_UPDATE);
    assign settle_cnt = (state_q == ST_SETTLE);

    amp_decider #(.DATA_W(DATA_W)) u_decider (
        .clk       (clk),
        .rst       (rst),
        .cap_i     (cap),
        .amp_i     (adc_data_i),
        .judge_i   (judge_en),
        .target_i  (target_i),
        .band_i    (band_i),
        .verdict_o (verdict)
    );

    dac_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk    (clk),
        .rst    (rst),
        .step_i (step_en),
        .dir_i  (verdict.dir),
        .code_o (dac_code_o)
    );

    settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .load_i    (step_en),
        .value_i   (settle_i),
        .count_i   (settle_cnt),
        .expired_o (settle_done)
    );

    lock_tracker #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step_en),
        .in_band_i   (verdict.in_band),
        .done_o      (done_q),
        .done_next_o (done_next)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_SAMPLE;
            ST_SAMPLE: if (adc_done_i) state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_UPDATE;
            ST_UPDATE: state_d = (!done_next || win_i) ? ST_SETTLE : ST_HOLD;
            ST_SETTLE: begin
                if (done_q && !win_i) begin
                    state_d = ST_HOLD;
                end else if (settle_done) begin
                    state_d = ST_SAMPLE;
                end
            end
            ST_HOLD:   if (win_i) state_d = ST_SAMPLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign adc_req_o  = (state_q == ST_SAMPLE);
    assign cal_done_o = done_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (adc_req_o && !adc_done_i) |=> adc_req_o)
        else $error("request dropped before done"); // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !win_i) |=> (!adc_req_o && $stable(dac_code_o)))
        else $error("activity in hold without window"); // R8
    AST_DEAD_BAND: assert property (@(posedge clk) disable iff (rst)
        (step_en && verdict.dir == STEP_NONE) |=> $stable(dac_code_o))
        else $error("code moved on in-band reading"); // R3
    AST_CODE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_UPDATE) |=> $stable(dac_code_o))
        else $error("code moved outside update"); // R11

endmodule

// File: tb/osc_amp_regulator_tb_top.sv
module osc_amp_regulator_tb_top;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 8;
    localparam int SETTLE_W = 8;
    localparam int LOCK     = 3;
    localparam int CMAX     = 255;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                win_i = 1'b0;
    logic [DATA_W-1:0]   target_i = '0;
    logic [DATA_W-1:0]   band_i = '0;
    logic [SETTLE_W-1:0] settle_i = '0;
    logic                adc_req_o;
    logic                adc_done_i = 1'b0;
    logic [DATA_W-1:0]   adc_data_i = '0;
    logic [CODE_W-1:0]   dac_code_o;
    logic                cal_done_o;

    always #5 clk = ~clk;

    osc_amp_regulator #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .SETTLE_W(SETTLE_W), .LOCK_COUNT(LOCK)
    ) dut_i (
        .clk(clk), .rst(rst), .win_i(win_i), .target_i(target_i), .band_i(band_i),
        .settle_i(settle_i), .adc_req_o(adc_req_o), .adc_done_i(adc_done_i),
        .adc_data_i(adc_data_i), .dac_code_o(dac_code_o), .cal_done_o(cal_done_o)
    );

    int tests = 0;
    int fails = 0;
    int m_code = 128;
    int m_done = 0;
    int m_run = 0;
    int m_settle = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dir(int amp, int tgt, int band);
        if (amp + band < tgt) return 1;
        if (amp > tgt + band) return -1;
        return 0;
    endfunction

    function automatic int clamp8(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    // Serve one conversion; returns at the negedge after the accepting edge.
    task automatic serve(input int data, input int tgt, input int band, input int stl,
                         input bit gap_chk, input bit drop_win);
        int n = 0;
        int d;
        while (!adc_req_o) begin
            @(posedge clk); n++; @(negedge clk);
        end
        if (gap_chk) chk(n == m_settle + 3, "R6 settle gap", n, m_settle + 3);
        chk(dac_code_o == CODE_W'(m_code), "R3/R11 code after step", int'(dac_code_o), m_code);
        chk(cal_done_o == m_done[0], "R7 done flag", int'(cal_done_o), m_done);
        target_i = DATA_W'(tgt);
        band_i   = DATA_W'(band);
        settle_i = SETTLE_W'(stl);
        if (drop_win) win_i = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        chk(adc_req_o == 1'b1, "R5 request held", int'(adc_req_o), 1);
        adc_data_i = DATA_W'(data);
        adc_done_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        adc_done_i = 1'b0;
        d = exp_dir(data, tgt, band);
        if (d > 0 && m_code < CMAX) m_code++;
        if (d < 0 && m_code > 0) m_code--;
        if (d == 0) begin
            if (m_run < LOCK) m_run++;
        end else begin
            m_run = 0;
        end
        if (m_run == LOCK) m_done = 1;
        m_settle = stl;
    endtask

    task automatic expect_idle(input int cycles, input string tag);
        bit seen = 1'b0;
        repeat (cycles) begin
            @(negedge clk);
            if (adc_req_o) seen = 1'b1;
        end
        chk(!seen, {tag, " no request in hold"}, int'(seen), 0);
        chk(dac_code_o == CODE_W'(m_code), {tag, " code frozen"}, int'(dac_code_o), m_code);
    endtask

    task automatic wait_req_edges(input int exp, input string tag);
        int n = 0;
        while (!adc_req_o && n < 50) begin
            @(posedge clk); n++; @(negedge clk);
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic run_all();
        int iter;
        int tgt;
        int band;
        int prev;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // R1 reset state
        repeat (4) @(negedge clk);
        chk(dac_code_o == 8'd128, "R1 reset code", int'(dac_code_o), 128);
        chk(cal_done_o == 1'b0, "R1 reset done", int'(cal_done_o), 0);
        chk(adc_req_o == 1'b0, "R1 reset request", int'(adc_req_o), 0);
        rst = 1'b0;
        chk(dac_code_o == 8'd128, "R1 code after release", int'(dac_code_o), 128);
        // R2 calibration starts without a window
        wait_req_edges(1, "R2 calibration start");
        // R7 calibration until lock
        iter = 0;
        while (!m_done && iter < 60) begin
            serve(clamp8(m_code + 20 + int'($urandom % 3) - 1), 150, 1, int'($urandom % 4), iter > 0, 1'b0);
            iter++;
        end
        chk(m_done == 1, "R7 calibration locked in time", m_done, 1);
        expect_idle(40, "R8");
        chk(cal_done_o == 1'b1, "R7 done after calibration", int'(cal_done_o), 1);
        // R10 resume from hold
        win_i = 1'b1;
        wait_req_edges(1, "R10 resume on window");
        // R3 dead-band edges, target 100 band 3, then band 0
        serve(103, 100, 3, 1, 1'b0, 1'b0);
        serve(104, 100, 3, 1, 1'b1, 1'b0);
        serve(97, 100, 3, 1, 1'b1, 1'b0);
        serve(96, 100, 3, 1, 1'b1, 1'b0);
        serve(100, 100, 0, 0, 1'b1, 1'b0);
        serve(101, 100, 0, 0, 1'b1, 1'b0);
        serve(99, 100, 0, 0, 1'b1, 1'b0);
        // Random tracking inside the window
        for (int k = 0; k < 60; k++) begin
            tgt  = 40 + int'($urandom % 180);
            band = int'($urandom % 5);
            serve(tgt - 8 + int'($urandom % 17), tgt, band, int'($urandom % 8), 1'b1, 1'b0);
        end
        // R9 window closes while a request is pending; step still applied
        prev = m_code;
        serve(0, 100, 2, 3, 1'b1, 1'b1);
        expect_idle(30, "R9");
        chk(int'(dac_code_o) == prev + 1 || (prev == CMAX && int'(dac_code_o) == CMAX),
            "R9 pending step applied", int'(dac_code_o), prev + 1);
        // R4 saturation at full scale
        win_i = 1'b1;
        wait_req_edges(1, "R10 resume after drop");
        iter = 0;
        while (iter < 5) begin
            serve(0, 255, 0, int'($urandom % 3), m_code != prev + 1 || iter > 0, 1'b0);
            if (m_code == CMAX) iter++;
        end
        chk(dac_code_o == 8'd255, "R4 saturate high", int'(dac_code_o), 255);
        // R4 saturation at zero
        iter = 0;
        while (iter < 5) begin
            serve(255, 0, 0, int'($urandom % 3), 1'b1, 1'b0);
            if (m_code == 0) iter++;
        end
        serve(10, 10, 0, 0, 1'b1, 1'b0);
        chk(dac_code_o == 8'd0, "R4 saturate low", int'(dac_code_o), 0);
        expect_idle(0, "R11");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                tests++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule